// File: doc/BRIEF.md
# I2C Target with Byte-Event State Code

This block is the target (slave) side of an I2C bus, sitting beside a host processor. It watches SCL and SDA on its system clock and recognises START, repeated START and STOP. It compares each address byte with a programmable 8-bit address register and acknowledges a match. After that it shifts data bytes in from the controller or out to it.

Each time a byte completes, the block pauses the bus by holding SCL low. It then presents an 8-bit state code with a one-cycle event strobe. Bit 7 of the code is the direction: 0 means the controller writes, 1 means the controller reads. Bits 6:0 count the bytes since the address byte, so the address byte itself is count 0. The host answers in one of three ways:
- it takes the received byte, which also frees the clock;
- it supplies the next byte to transmit, which frees the clock for read transfers;
- after a read-address event it may keep the clock held, then free it with an explicit release.

The controller FSM has eight states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: shifting in the address byte.
- `ST_RX`: shifting in a data byte.
- `ST_HOLD`: SCL is held low, waiting for the host.
- `ST_ACKBIT`: the target's ACK bit is being clocked.
- `ST_TX`: shifting a byte out, MSB first.
- `ST_TXACK`: sampling the controller's ACK or NACK.
- `ST_SKIP`: ignoring the bus until the next START or STOP.

The FSM moves between these states as follows:
- A START in any state leads to `ST_ADDR`. A STOP in any state leads to `ST_IDLE`.
- `ST_ADDR` goes to `ST_HOLD` on an address match at the end of the byte. On a mismatch it goes to `ST_SKIP`.
- `ST_RX` goes to `ST_HOLD` at the end of the byte.
- `ST_HOLD` goes to `ST_TX` on release when the code is above 0x80. Otherwise it goes to `ST_ACKBIT`.
- `ST_ACKBIT` goes to `ST_TX` for a read transfer and to `ST_RX` for a write transfer. Both moves happen on the falling edge of SCL.
- `ST_TX` goes to `ST_TXACK` after eight bits.
- `ST_TXACK` goes to `ST_HOLD` if the controller sends ACK, or to `ST_SKIP` if it sends NACK.

Top module: `i2c_target_evt`

## Requirements
- R1: When an address byte matches with direction bit 0 (write), the target drives ACK, sets `state_code` to 0x00 and pulses `evt`.
- R2: Each further byte written in the same transaction is acknowledged and presented on `rx_data`. It raises `state_code` by one: 0x01, 0x02, and so on.
- R3: When an address byte matches with direction bit 1 (read), the target drives ACK and sets `state_code` to 0x80. The first byte sent is the last value given with `tx_load`, shifted out MSB first.
- R4: After each byte the controller reads and acknowledges, `state_code` rises by one from 0x81. The byte supplied with `tx_load` is then sent MSB first.
- R5: Bits 6:0 of `state_code` saturate at 0x7F. Bit 7 changes only on an address byte, never from a count overflow.
- R6: From the `evt` pulse on, `scl_drive_low` stays high until the host releases it. For codes below 0x80, a `rd_ack` pulse releases it.
- R7: At code 0x80, `rd_ack` with `rd_hold` high keeps SCL low. A later `clk_release` pulse frees it. At codes above 0x80, `tx_load` frees it.
- R8: Only bits 7:1 of `own_addr` are compared with the address byte. On a mismatch there is no ACK and no `evt`, and the bus is ignored until the next START or STOP.
- R9: Reserved `own_addr` values 0x00 to 0x0F, 0xFE and 0xFF are never acknowledged. 0x10 is the lowest value that is acknowledged.
- R10: After the controller NACKs a read byte, the target stops driving SDA. It reports no further event until a START.
- R11: A repeated START restarts the count. The next address byte gives 0x00 or 0x80 according to its direction bit.
- R12: `evt` is high for exactly one system clock per byte event. After reset, `state_code` is 0, `evt` is 0 and neither bus line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low (ACK or a 0 data bit) |
| own_addr | input | 8 | Target address in 8-bit form; bit 0 ignored |
| rx_data | output | 8 | Last byte received (address or data) |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Strobe: accept `tx_data` |
| rd_ack | input | 1 | Strobe: host has taken `rx_data` |
| rd_hold | input | 1 | With `rd_ack` at code 0x80: keep SCL held |
| clk_release | input | 1 | Strobe: free a held SCL |
| state_code | output | 8 | Direction bit 7 plus byte count bits 6:0 |
| evt | output | 1 | One-cycle strobe when a new state code is valid |

## Verification
The hardest situation to reach is the count saturation, which needs one transaction of well over a hundred written bytes. The bench drives 130 data bytes after one address. It checks every logged code against the clamped index, then issues a repeated START with a read address to show that bit 7 still comes only from the direction bit. The held-clock option at 0x80 is reached by a host model that answers that one event with `rd_ack` and `rd_hold` together. It then waits several cycles, watching SCL stay low, before pulsing `clk_release`. The address decoder is swept across all 128 seven-bit addresses against one own address and across every reserved own address.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_HOLD,
        ST_ACKBIT,
        ST_TX,
        ST_TXACK,
        ST_SKIP
    } i2ct_state_e;
endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], line_i};
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~chain[STAGES];
    assign fall_o  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/i2ct_bus_cond.sv
module i2ct_bus_cond (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    assign start_o = sda_fall & scl_lvl;
    assign stop_o  = sda_rise & scl_lvl;
endmodule

// File: rtl/i2ct_code_ctr.sv
module i2ct_code_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         dir_i,
    input  logic         step_i,
    output logic [W-1:0] code_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
        end else if (load_i) begin
            code_o <= {dir_i, {(W-1){1'b0}}};
        end else if (step_i && (code_o[W-2:0] != '1)) begin
            code_o <= code_o + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_target_evt.sv
module i2c_target_evt
    import i2ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic [BYTE_W-1:0] own_addr,
    output logic [BYTE_W-1:0] rx_data,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_load,
    input  logic              rd_ack,
    input  logic              rd_hold,
    input  logic              clk_release,
    output logic [BYTE_W-1:0] state_code,
    output logic              evt
);
    localparam int              CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(BYTE_W);
    localparam logic [BYTE_W-1:0] RD_ADDR_CODE = {1'b1, {(BYTE_W-1){1'b0}}};

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start, stop;

    i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

    i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

    i2ct_bus_cond u_cond (
        .scl_lvl(scl_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .start_o(start), .stop_o(stop));

    i2ct_state_e       st, nxt;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx_buf;
    logic              rd_dir;
    logic              nack_q;

    logic own_valid, addr_ok, byte_done, code_tx, code_rd_addr, rel_ev;
    logic ctr_load, ctr_step;
    logic [BYTE_W-1:0] tx_src;

    assign own_valid    = (own_addr[BYTE_W-1:4] != '0) && (own_addr[BYTE_W-1:1] != '1);
    assign addr_ok      = own_valid && (shreg[BYTE_W-1:1] == own_addr[BYTE_W-1:1]);
    assign byte_done    = scl_fall && (bitcnt == LAST);
    assign code_rd_addr = (state_code == RD_ADDR_CODE);
    assign code_tx      = state_code[BYTE_W-1] && !code_rd_addr;
    assign rel_ev       = clk_release
                        | (rd_ack & ~state_code[BYTE_W-1])
                        | (rd_ack & code_rd_addr & ~rd_hold)
                        | (tx_load & code_tx);
    assign tx_src       = tx_load ? tx_data : tx_buf;

    assign ctr_load = (st == ST_ADDR) && byte_done && addr_ok;
    assign ctr_step = ((st == ST_RX) && byte_done) ||
                      ((st == ST_TXACK) && scl_fall && !nack_q);

    i2ct_code_ctr #(.W(BYTE_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(ctr_load), .dir_i(shreg[0]),
        .step_i(ctr_step), .code_o(state_code));

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:   nxt = ST_IDLE;
            ST_ADDR:   if (byte_done) nxt = addr_ok ? ST_HOLD : ST_SKIP;
            ST_RX:     if (byte_done) nxt = ST_HOLD;
            ST_HOLD:   if (rel_ev) nxt = code_tx ? ST_TX : ST_ACKBIT;
            ST_ACKBIT: if (scl_fall) nxt = rd_dir ? ST_TX : ST_RX;
            ST_TX:     if (byte_done) nxt = ST_TXACK;
            ST_TXACK:  if (scl_fall) nxt = nack_q ? ST_SKIP : ST_HOLD;
            ST_SKIP:   nxt = ST_SKIP;
            default:   nxt = ST_IDLE;
        endcase
        if (start)     nxt = ST_ADDR;
        else if (stop) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt        <= '0;
            shreg         <= '0;
            tx_buf        <= '0;
            rx_data       <= '0;
            rd_dir        <= 1'b0;
            nack_q        <= 1'b0;
            sda_drive_low <= 1'b0;
            scl_drive_low <= 1'b0;
            evt           <= 1'b0;
        end else begin
            evt <= ctr_load | ctr_step;
            if (tx_load) tx_buf <= tx_data;
            if (start || stop) begin
                bitcnt        <= '0;
                sda_drive_low <= 1'b0;
                scl_drive_low <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                            shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            if ((st == ST_RX) || addr_ok) begin
                                rx_data       <= shreg;
                                sda_drive_low <= 1'b1;
                                scl_drive_low <= 1'b1;
                                if (st == ST_ADDR) rd_dir <= shreg[0];
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (rel_ev) begin
                            if (code_tx) begin
                                // SDA first; SCL freed one cycle later in ST_TX
                                shreg         <= tx_src;
                                sda_drive_low <= ~tx_src[BYTE_W-1];
                                bitcnt        <= '0;
                            end else begin
                                scl_drive_low <= 1'b0;
                            end
                        end
                    end
                    ST_ACKBIT: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rd_dir) begin
                                shreg         <= tx_buf;
                                sda_drive_low <= ~tx_buf[BYTE_W-1];
                            end else begin
                                sda_drive_low <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        scl_drive_low <= 1'b0;
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            sda_drive_low <= 1'b0;
                            bitcnt        <= '0;
                        end else if (scl_fall && (bitcnt != '0)) begin
                            shreg         <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_drive_low <= ~shreg[BYTE_W-2];
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) begin
                            nack_q <= sda_lvl;
                        end else if (scl_fall && !nack_q) begin
                            scl_drive_low <= 1'b1;
                        end
                    end
                    ST_SKIP: sda_drive_low <= 1'b0;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2ct_checks.sv
module i2ct_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       evt,
    input logic [7:0] state_code,
    input logic       scl_drive_low,
    input logic       rd_ack,
    input logic       rd_hold,
    input logic       tx_load,
    input logic       clk_release
);
    p_evt_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

    p_stretch_on_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> scl_drive_low);

    p_release_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_low) |->
            ($past(rd_ack || clk_release) || $past(tx_load || clk_release, 2)));

    p_hold_rd_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_drive_low) && ($past(state_code) == 8'h80)) |->
            ($past(clk_release) || $past(rd_ack && !rd_hold)));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_code[6:0]) == 7'h7f) && !$stable(state_code)) |->
            (state_code[6:0] == 7'h00));

    p_dir_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && (state_code[6:0] != 7'h00)) |->
            (state_code[7] == $past(state_code[7])));
endmodule

bind i2c_target_evt i2ct_checks u_checks (
    .clk(clk), .rst_n(rst_n), .evt(evt), .state_code(state_code),
    .scl_drive_low(scl_drive_low), .rd_ack(rd_ack), .rd_hold(rd_hold),
    .tx_load(tx_load), .clk_release(clk_release));

// File: tb/i2c_target_evt_bench.sv
module i2c_target_evt_bench;
    localparam int T = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_drive_low, sda_drive_low;
    logic [7:0] own_addr = 8'h5A;
    logic [7:0] rx_data, tx_data = 8'h00, state_code;
    logic       tx_load = 1'b0, rd_ack = 1'b0, rd_hold = 1'b0, clk_release = 1'b0;
    logic       evt;
    logic       scl_bus, sda_bus;

    assign scl_bus = scl_m & ~scl_drive_low;
    assign sda_bus = sda_m & ~sda_drive_low;

    i2c_target_evt u_i2c_target_evt (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .own_addr(own_addr), .rx_data(rx_data), .tx_data(tx_data),
        .tx_load(tx_load), .rd_ack(rd_ack), .rd_hold(rd_hold),
        .clk_release(clk_release), .state_code(state_code), .evt(evt));

    always #4 clk = ~clk;

    int n_chk = 0, n_err = 0;
    int ev_n = 0;
    logic [7:0] ev_log [0:255];
    logic [7:0] rx_log [0:255];
    int stretch_bad = 0, hold_bad = 0, evt_long = 0;
    bit hold_mode = 1'b0;
    logic evt_prev = 1'b0;

    function automatic logic [7:0] tx_pat(input int i);
        return 8'hA5 ^ 8'(i * 37);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // host model
    task automatic pulse_tx(input logic [7:0] b);
        tx_data = b; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (evt) begin
                logic [7:0] cur;
                cur = state_code;
                if (ev_n < 256) begin
                    ev_log[ev_n] = state_code;
                    rx_log[ev_n] = rx_data;
                end
                ev_n++;
                repeat (12) begin
                    @(negedge clk);
                    if (!scl_drive_low) stretch_bad++;
                end
                if (cur < 8'h80) begin
                    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
                end else if (cur == 8'h80) begin
                    pulse_tx(tx_pat(0));
                    if (hold_mode) begin
                        rd_hold = 1'b1; rd_ack = 1'b1; @(negedge clk);
                        rd_hold = 1'b0; rd_ack = 1'b0;
                        repeat (30) begin
                            @(negedge clk);
                            if (!scl_drive_low) hold_bad++;
                        end
                        clk_release = 1'b1; @(negedge clk); clk_release = 1'b0;
                    end else begin
                        rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
                    end
                end else begin
                    pulse_tx(tx_pat(int'(cur) - 128));
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (evt && evt_prev) evt_long++;
            evt_prev = evt;
        end
    end

    // controller model
    task automatic m_start();
        sda_m = 1'b1; wt(T); scl_m = 1'b1; wait (scl_bus); wt(T);
        sda_m = 1'b0; wt(T); scl_m = 1'b0; wt(T);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wt(T); scl_m = 1'b1; wait (scl_bus); wt(T);
        sda_m = 1'b1; wt(T);
    endtask

    task automatic m_bit_w(input logic b);
        sda_m = b; wt(T); scl_m = 1'b1; wait (scl_bus); @(negedge clk); wt(T);
        scl_m = 1'b0; wt(T);
    endtask

    task automatic m_bit_r(output logic b);
        sda_m = 1'b1; wt(T); scl_m = 1'b1; wait (scl_bus); @(negedge clk); wt(T);
        b = sda_bus; scl_m = 1'b0; wt(T);
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic nack);
        for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
        m_bit_r(nack);
    endtask

    task automatic m_rbyte(output logic [7:0] d, input logic nack);
        logic b;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            m_bit_r(b);
            d = {d[6:0], b};
        end
        m_bit_w(nack);
    endtask

    logic       nk;
    logic [7:0] rb;
    int         bad;

    initial begin
        wt(5);
        // R12: reset state
        chk(state_code == 8'h00, "R12 reset code", state_code, 0);
        chk(evt == 1'b0, "R12 reset evt", evt, 0);
        chk(!scl_drive_low && !sda_drive_low, "R12 reset lines idle",
            {scl_drive_low, sda_drive_low}, 0);
        rst_n = 1'b1;
        wt(5);

        // R1, R2: write transaction
        ev_n = 0;
        m_start();
        m_wbyte(8'h5A, nk);
        chk(nk == 1'b0, "R1 address ack", nk, 0);
        for (int k = 0; k < 3; k++) begin
            m_wbyte(8'h3C + 8'(k * 65), nk);
            chk(nk == 1'b0, "R2 data ack", nk, 0);
        end
        m_stop();
        chk(ev_n == 4, "R2 event count", ev_n, 4);
        chk(ev_log[0] == 8'h00, "R1 code", ev_log[0], 0);
        for (int k = 1; k < 4; k++) begin
            chk(ev_log[k] == 8'(k), "R2 code", ev_log[k], k);
            chk(rx_log[k] == 8'h3C + 8'((k - 1) * 65), "R2 rx_data",
                rx_log[k], 8'h3C + 8'((k - 1) * 65));
        end
        chk(stretch_bad == 0, "R6 held until rd_ack", stretch_bad, 0);

        // R3, R4, R10: read transaction
        ev_n = 0;
        m_start();
        m_wbyte(8'h5B, nk);
        chk(nk == 1'b0, "R3 address ack", nk, 0);
        for (int k = 0; k < 4; k++) begin
            m_rbyte(rb, k == 3);
            chk(rb == tx_pat(k), k == 0 ? "R3 first byte" : "R4 next byte", rb, tx_pat(k));
        end
        chk(ev_n == 4, "R4 event count", ev_n, 4);
        for (int k = 0; k < 4; k++)
            chk(ev_log[k] == 8'h80 + 8'(k), "R4 code", ev_log[k], 128 + k);
        chk(sda_drive_low == 1'b0, "R10 SDA released after NACK", sda_drive_low, 0);
        m_rbyte(rb, 1'b1);
        chk(rb == 8'hFF, "R10 no drive after NACK", rb, 8'hFF);
        chk(ev_n == 4, "R10 no event after NACK", ev_n, 4);
        m_stop();

        // R11: repeated START
        ev_n = 0;
        m_start();
        m_wbyte(8'h5A, nk);
        m_wbyte(8'h11, nk);
        m_wbyte(8'h22, nk);
        m_start();
        m_wbyte(8'h5B, nk);
        m_rbyte(rb, 1'b0);
        m_rbyte(rb, 1'b1);
        m_stop();
        chk(ev_n == 5, "R11 event count", ev_n, 5);
        chk(ev_log[2] == 8'h02, "R11 before restart", ev_log[2], 2);
        chk(ev_log[3] == 8'h80, "R11 restart code", ev_log[3], 8'h80);
        chk(ev_log[4] == 8'h81, "R11 after restart", ev_log[4], 8'h81);

        // R7: held clock at read address
        hold_mode = 1'b1;
        ev_n = 0;
        m_start();
        m_wbyte(8'h5B, nk);
        m_rbyte(rb, 1'b1);
        m_stop();
        hold_mode = 1'b0;
        chk(hold_bad == 0, "R7 SCL kept low with rd_hold", hold_bad, 0);
        chk(rb == tx_pat(0), "R7 byte after clk_release", rb, tx_pat(0));

        // R8: sweep all 7-bit addresses against own 0x5A
        ev_n = 0;
        for (int a = 0; a < 128; a++) begin
            m_start();
            m_wbyte({7'(a), 1'b0}, nk);
            m_stop();
            chk(nk == (a != 8'h2D), "R8 address compare", nk, a != 8'h2D);
        end
        chk(ev_n == 1, "R8 single event in sweep", ev_n, 1);

        // R9: reserved own addresses
        ev_n = 0;
        for (int r = 0; r < 10; r++) begin
            own_addr = (r < 8) ? 8'(r * 2) : ((r == 8) ? 8'hFE : 8'hFF);
            m_start();
            m_wbyte({own_addr[7:1], 1'b0}, nk);
            m_stop();
            chk(nk == 1'b1, "R9 reserved not acked", nk, 1);
        end
        chk(ev_n == 0, "R9 no event", ev_n, 0);
        own_addr = 8'h10;
        m_start();
        m_wbyte(8'h10, nk);
        m_stop();
        chk(nk == 1'b0, "R9 0x10 acked", nk, 0);
        own_addr = 8'h5A;

        // R5: saturation over 130 data bytes
        ev_n = 0;
        m_start();
        m_wbyte(8'h5A, nk);
        for (int k = 0; k < 130; k++) m_wbyte(8'(k), nk);
        bad = 0;
        for (int k = 0; k < 131; k++)
            if (ev_log[k] != 8'((k > 127) ? 127 : k)) bad++;
        chk(ev_n == 131, "R5 event count", ev_n, 131);
        chk(bad == 0, "R5 clamped codes", bad, 0);
        chk(ev_log[130] == 8'h7F, "R5 final code", ev_log[130], 8'h7F);
        m_start();
        m_wbyte(8'h5B, nk);
        m_rbyte(rb, 1'b1);
        m_stop();
        chk(ev_log[131] == 8'h80, "R5 direction from address", ev_log[131], 8'h80);

        chk(evt_long == 0, "R12 evt single cycle", evt_long, 0);
        chk(stretch_bad == 0, "R6 held on all events", stretch_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule